// File: doc/BRIEF.md
# Two-Wire Bus Condition Detector

This block is the receive-side front end of a two-wire serial slave. It takes the raw clock line and data line from the pads and brings both into the system clock domain through a configurable synchroniser chain. Each line then passes through a digital persistence filter: a new level is accepted only after it has been seen without a break for a set number of system clocks. Anything shorter is treated as a spike and discarded.

From the two filtered lines the block produces single-cycle strobes: a start marker when the data line falls while the clock line is high, a stop marker when the data line rises while the clock line is high, a data-bit strobe with the sampled bit on each clock rising edge, and a clock-falling strobe. A level output reports an idle bus, which means both lines are high. On the transmit side the slave's request to pull the data line low goes through a gate. The gate updates the open-drain enable only while the filtered clock is low, and only after a programmable hold time has passed since the clock fell. This keeps the slave from ever creating a false start or stop.

Top module: `twi_bus_front`

## Requirements
- R1: During reset and in the first cycle after reset release with both lines high, start_evt, stop_evt, bit_valid and scl_fall are 0, sda_oe is 0 and bus_idle is 1.
- R2: A falling data line while the filtered clock line is high produces exactly one single-cycle start_evt pulse.
- R3: A rising data line while the filtered clock line is high produces exactly one single-cycle stop_evt pulse, and bus_idle is 1 in that cycle.
- R4: Each filtered rising edge of the clock line produces exactly one bit_valid pulse, and bit_val then equals the filtered data level. Eight rising edges deliver a byte MSB first with no bit lost or swapped, for every byte value.
- R5: Each filtered falling edge of the clock line produces exactly one single-cycle scl_fall pulse.
- R6: A pulse on either line lasting fewer than FILT_CYC system clocks produces no event. A level held for FILT_CYC clocks or more is accepted.
- R7: Data-line changes while the clock line is low produce neither start_evt nor stop_evt.
- R8: When a clock rise and a data change are accepted in the same cycle, the start or stop event is reported and bit_valid is suppressed. At most one of start_evt, stop_evt and bit_valid is high in any cycle.
- R9: After a clock fall, sda_oe takes the value of sda_drive_req exactly HOLD_CYC+1 cycles after the scl_fall pulse, and no earlier.
- R10: While the filtered clock line is high, sda_oe does not change, whatever sda_drive_req does.
- R11: bus_idle is 1 exactly when both filtered lines are high (registered one cycle), and it is 0 while a byte is being clocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw clock line from the pad |
| sda_in | input | 1 | Raw data line from the pad |
| sda_drive_req | input | 1 | Slave request to pull the data line low |
| sda_oe | output | 1 | Gated open-drain enable for the data line (1 = drive low) |
| start_evt | output | 1 | Single-cycle start condition strobe |
| stop_evt | output | 1 | Single-cycle stop condition strobe |
| bit_valid | output | 1 | Single-cycle strobe on an accepted clock rising edge |
| bit_val | output | 1 | Data level sampled with bit_valid |
| scl_fall | output | 1 | Single-cycle strobe on an accepted clock falling edge |
| bus_idle | output | 1 | Both filtered lines high |

## Verification
A filter counter that is wrong in state shows up at once, within one filter window of the stimulus. It either lets a short spike through as a spurious start or stop, or it drops a valid edge, and the byte reassembled from bit_val then differs. A wrong hold counter or gate state moves the cycle in which sda_oe changes. That is seen as a gap other than HOLD_CYC+1 after the scl_fall pulse, or as an enable that moves during the clock-high phase. Stale edge history in the detector shows up as a missing or doubled strobe on the very next edge.

// File: rtl/twi_fe_pkg.sv
package twi_fe_pkg;

   // width needed to hold values 0..n
   function automatic int cnt_width(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

   typedef struct packed {
      logic start;
      logic stop;
      logic bit_strobe;
      logic bit_value;
      logic clk_fall;
      logic idle;
   } twi_evt_t;

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("twi_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= RST_VAL;
               else        chain[gi] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= RST_VAL;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q_out = chain[STAGES-1];

endmodule

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter
   import twi_fe_pkg::*;
#(
   parameter int FILT_CYC = 10,
   parameter bit RST_VAL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);

   localparam int CW = cnt_width(FILT_CYC);

   generate
      if (FILT_CYC < 1) begin : g_bad_filt
         $error("twi_glitch_filter: FILT_CYC must be at least 1");
      end
   endgenerate

   logic q_r;

   generate
      if (FILT_CYC == 1) begin : g_pass
         // a single sample is enough: plain register
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= RST_VAL;
            else        q_r <= d_in;
         end
      end else begin : g_persist
         logic [CW-1:0] run_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_r     <= RST_VAL;
               run_cnt <= '0;
            end else if (d_in == q_r) begin
               run_cnt <= '0;
            end else if (run_cnt == CW'(FILT_CYC - 1)) begin
               q_r     <= d_in;
               run_cnt <= '0;
            end else begin
               run_cnt <= run_cnt + 1'b1;
            end
         end
      end
   endgenerate

   assign q_out = q_r;

   // R6: an accepted level is one that was present at the input
   a_r6_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(q_r) |-> ($past(d_in) == q_r));

endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect
   import twi_fe_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_f,
   input  logic     sda_f,
   output twi_evt_t evt
);

   logic scl_d, sda_d;
   logic start_c, stop_c, rise_c, fall_c;

   always_comb begin
      start_c = scl_f &  sda_d & ~sda_f;
      stop_c  = scl_f & ~sda_d &  sda_f;
      rise_c  = scl_f & ~scl_d;
      fall_c  = scl_d & ~scl_f;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
         evt   <= '{start: 1'b0, stop: 1'b0, bit_strobe: 1'b0,
                    bit_value: 1'b0, clk_fall: 1'b0, idle: 1'b1};
      end else begin
         scl_d          <= scl_f;
         sda_d          <= sda_f;
         evt.start      <= start_c;
         evt.stop       <= stop_c;
         evt.bit_strobe <= rise_c & ~start_c & ~stop_c;
         if (rise_c) evt.bit_value <= sda_f;
         evt.clk_fall   <= fall_c;
         evt.idle       <= scl_f & sda_f;
      end
   end

   // R5: a fall strobe never lasts two cycles
   a_r5_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
      evt.clk_fall |=> !evt.clk_fall);

endmodule

// File: rtl/twi_sda_gate.sv
module twi_sda_gate
   import twi_fe_pkg::*;
#(
   parameter int HOLD_CYC = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic drive_req,
   output logic sda_oe
);

   localparam int HW = cnt_width(HOLD_CYC);

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("twi_sda_gate: HOLD_CYC must be at least 1");
      end
   endgenerate

   logic          scl_q;
   logic          fall_now;
   logic [HW-1:0] hold_cnt;
   logic          window_open;

   always_comb begin
      fall_now    = scl_q & ~scl_f;
      window_open = ~scl_f & ~fall_now & (hold_cnt == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q    <= 1'b1;
         hold_cnt <= '0;
         sda_oe   <= 1'b0;
      end else begin
         scl_q <= scl_f;
         if (fall_now)
            hold_cnt <= HW'(HOLD_CYC);
         else if (~scl_f && hold_cnt != '0)
            hold_cnt <= hold_cnt - 1'b1;
         if (window_open)
            sda_oe <= drive_req;
      end
   end

   // R10: enable only moves when the clock line was low
   a_r10_oe_only_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !$past(scl_f));

endmodule

// File: rtl/twi_bus_front.sv
module twi_bus_front
   import twi_fe_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYC    = 10,
   parameter int HOLD_CYC    = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   input  logic sda_drive_req,
   output logic sda_oe,
   output logic start_evt,
   output logic stop_evt,
   output logic bit_valid,
   output logic bit_val,
   output logic scl_fall,
   output logic bus_idle
);

   logic     scl_s, sda_s;
   logic     scl_f, sda_f;
   twi_evt_t evt;

   twi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d_in(scl_in), .q_out(scl_s));
   twi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d_in(sda_in), .q_out(sda_s));

   twi_glitch_filter #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b1)) u_filt_scl (
      .clk(clk), .rst_n(rst_n), .d_in(scl_s), .q_out(scl_f));
   twi_glitch_filter #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b1)) u_filt_sda (
      .clk(clk), .rst_n(rst_n), .d_in(sda_s), .q_out(sda_f));

   twi_cond_detect u_detect (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f), .evt(evt));

   twi_sda_gate #(.HOLD_CYC(HOLD_CYC)) u_gate (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f),
      .drive_req(sda_drive_req), .sda_oe(sda_oe));

   assign start_evt = evt.start;
   assign stop_evt  = evt.stop;
   assign bit_valid = evt.bit_strobe;
   assign bit_val   = evt.bit_value;
   assign scl_fall  = evt.clk_fall;
   assign bus_idle  = evt.idle;

   // R8: bus events are mutually exclusive
   a_r8_one_event: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_evt, stop_evt, bit_valid}));

   // R3: a stop always leaves the bus idle
   a_r3_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |-> bus_idle);

   // R9: the enable never moves in the cycle right after a clock fall strobe
   a_r9_no_early_oe: assert property (@(posedge clk) disable iff (!rst_n)
      scl_fall |=> $stable(sda_oe));

endmodule

// File: tb/sim_twi_bus_front.sv
`timescale 1ns/1ps
module sim_twi_bus_front;

   localparam int FILT = 10;
   localparam int HOLD = 60;
   localparam int PH   = FILT + 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda = 1'b1, drv = 1'b0;
   logic sda_oe, start_evt, stop_evt, bit_valid, bit_val, scl_fall, bus_idle;

   int n_tests = 0, n_fail = 0;
   int c_start = 0, c_stop = 0, c_bit = 0, c_fall = 0;
   logic [7:0] shreg = '0;
   int since_fall = 0, oe_gap = -1;
   logic oe_prev = 1'b0;

   always #2.5 clk = ~clk;

   twi_bus_front #(.SYNC_STAGES(2), .FILT_CYC(FILT), .HOLD_CYC(HOLD)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
      .sda_drive_req(drv), .sda_oe(sda_oe), .start_evt(start_evt),
      .stop_evt(stop_evt), .bit_valid(bit_valid), .bit_val(bit_val),
      .scl_fall(scl_fall), .bus_idle(bus_idle));

   always @(negedge clk) begin
      if (rst_n) begin
         if (start_evt) c_start++;
         if (stop_evt)  c_stop++;
         if (bit_valid) begin c_bit++; shreg = {shreg[6:0], bit_val}; end
         if (scl_fall) begin c_fall++; since_fall = 0; end
         else since_fall++;
         if (sda_oe !== oe_prev) oe_gap = since_fall;
         oe_prev = sda_oe;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clr();
      c_start = 0; c_stop = 0; c_bit = 0; c_fall = 0;
   endtask

   task automatic lines(input logic s, input logic d);
      @(negedge clk);
      scl = s; sda = d;
      repeat (PH) @(negedge clk);
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset values
      chk("R1 start", int'(start_evt), 0);
      chk("R1 stop", int'(stop_evt), 0);
      chk("R1 bit", int'(bit_valid), 0);
      chk("R1 fall", int'(scl_fall), 0);
      chk("R1 oe", int'(sda_oe), 0);
      chk("R1 idle", int'(bus_idle), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after release", int'(bus_idle), 1);
      repeat (PH) @(negedge clk);
      chk("R1 no events", c_start + c_stop + c_bit + c_fall, 0);

      // R6: short pulses on SDA while idle are rejected
      for (int w = 1; w < FILT; w++) begin
         clr();
         @(negedge clk); sda = 1'b0;
         repeat (w - 1) @(negedge clk);
         @(negedge clk); sda = 1'b1;
         repeat (PH) @(negedge clk);
         chk("R6 sda glitch start", c_start, 0);
         chk("R6 sda glitch stop", c_stop, 0);
      end
      // R6: pulse of FILT cycles accepted -> start then stop (R2, R3)
      clr();
      @(negedge clk); sda = 1'b0;
      repeat (FILT - 1) @(negedge clk);
      @(negedge clk); sda = 1'b1;
      repeat (PH) @(negedge clk);
      chk("R6 R2 full pulse start", c_start, 1);
      chk("R6 R3 full pulse stop", c_stop, 1);

      // R2: clean start
      clr();
      lines(1, 0);
      chk("R2 start count", c_start, 1);
      chk("R2 no stop", c_stop, 0);
      chk("R11 not idle", int'(bus_idle), 0);
      lines(0, 0);
      chk("R5 fall count", c_fall, 1);

      // R6: short SCL pulses while low are rejected
      clr();
      for (int w = 1; w < FILT; w++) begin
         @(negedge clk); scl = 1'b1;
         repeat (w - 1) @(negedge clk);
         @(negedge clk); scl = 1'b0;
         repeat (PH) @(negedge clk);
      end
      chk("R6 scl glitch bits", c_bit, 0);
      chk("R6 scl glitch falls", c_fall, 0);

      // R4 R5 R7 R11: every byte value
      for (int b = 0; b < 256; b++) begin
         clr();
         for (int i = 7; i >= 0; i--) begin
            lines(0, b[i]);
            lines(1, b[i]);
            lines(0, b[i]);
         end
         chk("R4 bit count", c_bit, 8);
         chk("R4 byte value", int'(shreg), b);
         chk("R5 fall per bit", c_fall, 8);
         chk("R7 no start/stop", c_start + c_stop, 0);
         if (b == 8'hA5) chk("R11 busy", int'(bus_idle), 0);
      end

      // R3 R11: stop
      clr();
      lines(0, 0);
      lines(1, 0);
      lines(1, 1);
      chk("R3 stop count", c_stop, 1);
      chk("R3 no start", c_start, 0);
      chk("R11 idle after stop", int'(bus_idle), 1);

      // R8: SCL rise with SDA fall in same cycle -> start, no bit
      lines(0, 1);
      clr();
      lines(1, 0);
      chk("R8 start", c_start, 1);
      chk("R8 bit suppressed", c_bit, 0);
      // R8: SCL rise with SDA rise -> stop, no bit
      lines(0, 0);
      clr();
      lines(1, 1);
      chk("R8 stop", c_stop, 1);
      chk("R8 bit suppressed on stop", c_bit, 0);

      // R9 R10: output gate
      lines(1, 0);        // start
      lines(0, 0);
      repeat (HOLD + 4) @(negedge clk);
      chk("R9 oe idle low", int'(sda_oe), 0);
      lines(1, 0);
      drv = 1'b1;         // request during clock high
      repeat (HOLD + 4) @(negedge clk);
      chk("R10 oe frozen high", int'(sda_oe), 0);
      oe_gap = -1;
      lines(0, 0);
      repeat (HOLD + 4) @(negedge clk);
      chk("R9 oe follows", int'(sda_oe), 1);
      chk("R9 hold gap", oe_gap, HOLD + 1);
      lines(1, 0);
      drv = 1'b0;
      repeat (HOLD + 4) @(negedge clk);
      chk("R10 oe held while high", int'(sda_oe), 1);
      oe_gap = -1;
      lines(0, 0);
      repeat (HOLD + 4) @(negedge clk);
      chk("R9 oe release", int'(sda_oe), 0);
      chk("R9 release gap", oe_gap, HOLD + 1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule